// File: doc/BRIEF.md
# Daisy-Chain Position Discovery Controller

This block holds the per-device chain mode that lets a bus master learn the physical order of devices strung along one cable. Two general-purpose open-drain pins are reused: pin B becomes an active-low enable input, and pin A becomes a done output that feeds the enable of the next device down the line. The master steps the devices one at a time. The first device has its enable tied low. Each device, once its identity has been read, is moved to the finished mode, and there it pulls its done output low. This enables the next device. At any moment only the single device in the armed mode with its enable low answers a conditional identity read.

The block has three modes, and only a decoded chain command moves it between them. IDLE is the reset mode: both pins behave as plain PIOs driven by their output latches. ARMED applies a weak pullup to pin A, watches pin B as the enable, and answers the conditional read when the enable is low. RELAYED switches pin A's pulldown on and ignores pin B. Every mode can reach every other mode, and a command naming the current mode keeps it. The transitions are: IDLE→ARMED, IDLE→RELAYED, ARMED→IDLE, ARMED→RELAYED, RELAYED→IDLE, RELAYED→ARMED, and the self-loops. The enable pin is asynchronous to the clock, so it passes through a flop synchronizer before use.

Top module: `seq_chain_ctrl`

## Requirements
- R1: After reset the mode is IDLE. With both latch inputs at 0, no pullup and no pulldown is enabled and `id_answer` is 0.
- R2: When `cmd_valid` is 1 at a rising clock edge, code 2'b00 selects IDLE, 2'b01 selects ARMED and 2'b10 selects RELAYED. The drive outputs show the new mode from that edge on.
- R3: Code 2'b11, or any edge with `cmd_valid` at 0, leaves the mode unchanged.
- R4: In IDLE, `a_pulldown_en` equals `latch_a`, `b_pulldown_en` equals `latch_b`, `a_pullup_en` is 0, and `id_answer` is 0.
- R5: In ARMED, `a_pullup_en` is 1, both pulldown enables are 0, and the latch inputs have no effect.
- R6: In RELAYED, `a_pulldown_en` is 1, `a_pullup_en` and `b_pulldown_en` are 0, and `id_answer` is 0.
- R7: `id_answer` is 1 only when `id_strobe` is 1, the mode is ARMED and the synchronized enable is 0. It follows `id_strobe` in the same cycle.
- R8: `en_n_pin` passes through SYNC_STAGES flops (default 2) that reset to 1. A level applied before edge k decides `id_answer` after edge k+1.
- R9: `a_pullup_en` and `a_pulldown_en` are never 1 together.
- R10: Every mode can be reached directly from every other mode by a single command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Chain command present this cycle |
| cmd_code | input | 2 | Chain command: 00 IDLE, 01 ARMED, 10 RELAYED, 11 ignored |
| en_n_pin | input | 1 | Pin B level, active-low enable (asynchronous) |
| id_strobe | input | 1 | Conditional identity read in progress |
| latch_a | input | 1 | PIO A output latch, 1 = pull pin low |
| latch_b | input | 1 | PIO B output latch, 1 = pull pin low |
| a_pullup_en | output | 1 | Weak pullup on pin A |
| a_pulldown_en | output | 1 | Pulldown on pin A |
| b_pulldown_en | output | 1 | Pulldown on pin B |
| id_answer | output | 1 | Device answers the conditional read |

## Verification
A mode command takes effect at the edge where it is sampled, so the drive outputs are due one cycle after the command is presented. `id_answer` responds to `id_strobe` within the same cycle. A change on the enable pin reaches `id_answer` only after the second edge. The bench applies inputs after the falling edge and compares against its reference model shortly afterwards. It advances the model's mode and its synchronizer queue only at rising edges, so every comparison lands in the cycle where the result is due.

// File: rtl/chain_pkg.sv
package chain_pkg;
    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        MODE_IDLE    = 2'b00,
        MODE_ARMED   = 2'b01,
        MODE_RELAYED = 2'b10
    } chain_mode_e;

    localparam logic [CMD_W-1:0] CODE_IDLE    = 2'b00;
    localparam logic [CMD_W-1:0] CODE_ARMED   = 2'b01;
    localparam logic [CMD_W-1:0] CODE_RELAYED = 2'b10;
    localparam logic [CMD_W-1:0] CODE_NONE    = 2'b11;
endpackage

// File: rtl/chain_sync.sv
module chain_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= RESET_VAL;
                else        pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= {STAGES{RESET_VAL}};
                else        pipe <= {pipe[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = pipe[LAST];
endmodule

// File: rtl/chain_fsm.sv
module chain_fsm
    import chain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output chain_mode_e      mode
);
    chain_mode_e mode_q;
    chain_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (cmd_valid) begin
            unique case (cmd_code)
                CODE_IDLE:    mode_d = MODE_IDLE;
                CODE_ARMED:   mode_d = MODE_ARMED;
                CODE_RELAYED: mode_d = MODE_RELAYED;
                CODE_NONE:    mode_d = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/chain_drive.sv
module chain_drive
    import chain_pkg::*;
(
    input  chain_mode_e mode,
    input  logic        latch_a,
    input  logic        latch_b,
    input  logic        en_sync_n,
    input  logic        id_strobe,
    output logic        a_pullup_en,
    output logic        a_pulldown_en,
    output logic        b_pulldown_en,
    output logic        id_answer
);
    always_comb begin
        a_pullup_en   = 1'b0;
        a_pulldown_en = 1'b0;
        b_pulldown_en = 1'b0;
        id_answer     = 1'b0;
        unique case (mode)
            MODE_IDLE: begin
                a_pulldown_en = latch_a;
                b_pulldown_en = latch_b;
            end
            MODE_ARMED: begin
                a_pullup_en = 1'b1;
                id_answer   = id_strobe & ~en_sync_n;
            end
            MODE_RELAYED: begin
                a_pulldown_en = 1'b1;
            end
            default: begin
                a_pullup_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seq_chain_ctrl.sv
module seq_chain_ctrl
    import chain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             en_n_pin,
    input  logic             id_strobe,
    input  logic             latch_a,
    input  logic             latch_b,
    output logic             a_pullup_en,
    output logic             a_pulldown_en,
    output logic             b_pulldown_en,
    output logic             id_answer
);
    chain_mode_e mode;
    logic        en_sync_n;

    chain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (en_n_pin),
        .q     (en_sync_n)
    );

    chain_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .mode      (mode)
    );

    chain_drive u_drive (
        .mode          (mode),
        .latch_a       (latch_a),
        .latch_b       (latch_b),
        .en_sync_n     (en_sync_n),
        .id_strobe     (id_strobe),
        .a_pullup_en   (a_pullup_en),
        .a_pulldown_en (a_pulldown_en),
        .b_pulldown_en (b_pulldown_en),
        .id_answer     (id_answer)
    );
endmodule

// File: rtl/seq_chain_chk.sv
module seq_chain_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_code,
    input logic       en_n_pin,
    input logic       id_strobe,
    input logic       a_pullup_en,
    input logic       a_pulldown_en,
    input logic       b_pulldown_en,
    input logic       id_answer
);
    a_r9_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_pullup_en && a_pulldown_en));

    a_r2_enter_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b01) |=> (a_pullup_en && !a_pulldown_en && !b_pulldown_en));

    a_r2_enter_relayed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b10) |=> (a_pulldown_en && !a_pullup_en && !id_answer));

    a_r2_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b00) |=> (!a_pullup_en && !id_answer));

    a_r3_hold_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_code == 2'b11) |=> $stable(a_pullup_en));

    a_r7_answer_gate: assert property (@(posedge clk) disable iff (!rst_n)
        id_answer |-> (id_strobe && a_pullup_en));

    generate
        if (SYNC_STAGES == 2) begin : g_r8
            a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
                id_answer |-> !$past(en_n_pin, 2));
        end
    endgenerate
endmodule

bind seq_chain_ctrl seq_chain_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .en_n_pin      (en_n_pin),
    .id_strobe     (id_strobe),
    .a_pullup_en   (a_pullup_en),
    .a_pulldown_en (a_pulldown_en),
    .b_pulldown_en (b_pulldown_en),
    .id_answer     (id_answer)
);

// File: tb/sim_seq_chain_ctrl.sv
`timescale 1ns/1ps
module sim_seq_chain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'b00;
    logic       en_n_pin = 1'b1;
    logic       id_strobe = 1'b0;
    logic       latch_a = 1'b0;
    logic       latch_b = 1'b0;
    logic       a_pullup_en, a_pulldown_en, b_pulldown_en, id_answer;

    int n_checks = 0;
    int n_fails  = 0;

    int m_mode = 0;
    int m_sync[$] = '{1, 1};

    always #2 clk = ~clk;

    seq_chain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .en_n_pin(en_n_pin), .id_strobe(id_strobe), .latch_a(latch_a), .latch_b(latch_b),
        .a_pullup_en(a_pullup_en), .a_pulldown_en(a_pulldown_en),
        .b_pulldown_en(b_pulldown_en), .id_answer(id_answer)
    );

    task automatic check(input string tag);
        logic eu, ea, eb, ei;
        eu = (m_mode == 1);
        ea = (m_mode == 0) ? latch_a : (m_mode == 2);
        eb = (m_mode == 0) ? latch_b : 1'b0;
        ei = (m_mode == 1) && id_strobe && (m_sync[0] == 0);
        n_checks++;
        if ({a_pullup_en, a_pulldown_en, b_pulldown_en, id_answer} !== {eu, ea, eb, ei}) begin
            n_fails++;
            $display("FAIL %s: up/dnA/dnB/ans actual %b%b%b%b expected %b%b%b%b", tag,
                     a_pullup_en, a_pulldown_en, b_pulldown_en, id_answer, eu, ea, eb, ei);
        end
        n_checks++;
        if (a_pullup_en && a_pulldown_en) begin
            n_fails++;
            $display("FAIL R9: pullup and pulldown both on, actual 11 expected not 11");
        end
    endtask

    task automatic step(input logic cv, input logic [1:0] code, input logic pa, input logic pb,
                        input logic en, input logic strb, input string tag);
        cmd_valid = cv; cmd_code = code; latch_a = pa; latch_b = pb;
        en_n_pin = en; id_strobe = strb;
        #1;
        check(tag);
        @(posedge clk);
        if (rst_n) begin
            if (cv && code != 2'b11) m_mode = int'(code);
            m_sync.push_back(int'(en));
            void'(m_sync.pop_front());
        end
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R4: IDLE follows latches, no answer even with enable low
        step(0, 2'b00, 0, 0, 1, 0, "R1 idle after reset");
        step(0, 2'b00, 1, 0, 0, 1, "R4 latch a");
        step(0, 2'b00, 0, 1, 0, 1, "R4 latch b");
        step(0, 2'b00, 1, 1, 0, 1, "R4 both latches");
        // R3: unknown code in IDLE
        step(1, 2'b11, 1, 0, 0, 1, "R3 code 11 in idle");
        step(0, 2'b01, 1, 0, 0, 1, "R3 valid low in idle");
        // R2: enter ARMED, R5 latches ignored
        step(1, 2'b01, 1, 1, 1, 0, "R2 command armed");
        step(0, 2'b00, 1, 1, 1, 1, "R5 latches ignored");
        step(0, 2'b00, 0, 1, 1, 1, "R5 enable high no answer");
        // R8: enable falls, answer appears after second edge
        step(0, 2'b00, 0, 0, 0, 1, "R8 enable low edge 0");
        step(0, 2'b00, 0, 0, 0, 1, "R8 enable low edge 1");
        step(0, 2'b00, 0, 0, 0, 1, "R7 answer with strobe");
        step(0, 2'b00, 0, 0, 0, 0, "R7 no strobe no answer");
        step(0, 2'b00, 0, 0, 1, 1, "R8 enable rises, still old");
        step(0, 2'b00, 0, 0, 1, 1, "R8 enable high edge 1");
        step(0, 2'b00, 0, 0, 0, 1, "R7 enable high blocks");
        // R3 in ARMED
        step(1, 2'b11, 0, 0, 0, 1, "R3 code 11 in armed");
        step(0, 2'b10, 0, 0, 0, 1, "R3 valid low in armed");
        step(1, 2'b01, 0, 0, 0, 1, "R10 armed to armed");
        // R6 RELAYED
        step(1, 2'b10, 1, 1, 0, 1, "R2 command relayed");
        step(0, 2'b00, 1, 1, 0, 1, "R6 relayed drives low");
        step(0, 2'b00, 0, 1, 1, 0, "R6 pin b no function");
        step(1, 2'b11, 0, 0, 0, 1, "R3 code 11 in relayed");
        // R10: remaining transitions
        step(1, 2'b01, 0, 0, 0, 1, "R10 relayed to armed");
        step(1, 2'b00, 1, 0, 0, 1, "R10 armed to idle");
        step(1, 2'b10, 0, 1, 0, 1, "R10 idle to relayed");
        step(1, 2'b00, 0, 1, 0, 1, "R10 relayed to idle");
        step(1, 2'b00, 1, 1, 0, 1, "R10 idle to idle");
        step(1, 2'b01, 0, 0, 0, 1, "R10 idle to armed");
        step(1, 2'b10, 0, 0, 0, 1, "R10 armed to relayed");
        step(1, 2'b10, 0, 0, 0, 1, "R10 relayed to relayed");
        step(1, 2'b01, 0, 0, 0, 1, "R2 back to armed");
        step(0, 2'b00, 0, 0, 0, 1, "R7 armed answer again");
        // R1: reset in mid-run returns to IDLE and clears synchronizer
        rst_n = 1'b0;
        m_mode = 0;
        m_sync = '{1, 1};
        #1;
        step(0, 2'b00, 0, 0, 0, 1, "R1 reset mid run");
        rst_n = 1'b1;
        step(0, 2'b00, 0, 0, 0, 1, "R1 idle after second reset");
        step(1, 2'b01, 0, 0, 0, 1, "R8 armed after reset");
        step(0, 2'b00, 0, 0, 0, 1, "R8 sync filled");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule